// File: doc/BRIEF.md
# MII PHY Management Register File

This block holds the management registers of a Fast Ethernet PHY as a MAC sees them through an indirect access path. The MAC first loads a selector word that names a PHY address and a register index. The selected register then appears on a read-data output, and a one-cycle write strobe updates it. Only the PHY address given by a parameter answers. Any other address reads as all ones and accepts no writes.

Two registers hold state: basic control and auto-negotiation advertisement. The status register and the link-partner ability register are built from a registered copy of the `link_ok` input, so they follow the link without any bus access. The two identifier words are parameters. Writing the control register with bit 15 set does not store the written value. It reloads every default and applies the current link state again.

Top module: `phy_mgmt_regfile`

## Requirements
- R1: When the selector's PHY address field (bits 15:8 of `sel_wdata`) differs from `PHY_ADDR`, `rd_data` is 16'hFFFF and a write strobe changes no register.
- R2: After reset, control reads 16'h3100 (bit 13 speed 100, bit 12 auto-negotiation enable, bit 8 full duplex) and advertisement reads 16'h01E1 (bits 8, 7, 6, 5 and selector bit 0).
- R3: Status always reports abilities 16'h7848 (bits 14, 13, 12, 11: 100TX full/half and 10T full/half; bit 6: preamble suppression; bit 3: auto-negotiation ability). With the link up, link-status bit 2 and negotiation-complete bit 5 are also set, giving 16'h786C.
- R4: With the link down, status bits 2 and 5 are clear (16'h7848) and partner ability (index 5) holds only bit 7 (16'h0080). With the link up, partner ability reads 16'h01E1.
- R5: A control write (index 0) with bit 15 set reloads the control and advertisement defaults, keeps status and partner ability consistent with the current link, and does not store the written value.
- R6: A control write with bit 15 clear stores all 16 bits. An advertisement write (index 4) stores all 16 bits.
- R7: Writes to the read-only indices (1 status, 2 and 3 identifier, 5 partner ability, 6 expansion) change no register.
- R8: Index 2 reads `ID_HI`, index 3 reads `ID_LO`, and every other index except 0, 1, 4 and 5 reads zero and ignores writes. This covers index 6 and indices 7 up to 255.
- R9: A change on `link_ok` shows in status and partner ability on the next clock edge, with no bus access needed.
- R10: The register index is bits 7:0 of `sel_wdata`. The selector takes effect on the clock edge at which `sel_we` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_we | input | 1 | Load strobe for the selector word |
| sel_wdata | input | 16 | Selector: PHY address in bits 15:8, register index in bits 7:0 |
| wr_stb | input | 1 | Single-cycle write strobe for the selected register |
| wr_data | input | 16 | Write value |
| link_ok | input | 1 | Link indication |
| rd_data | output | 16 | Contents of the selected register, or 16'hFFFF for a foreign address |

## Verification
A wrong stored value in the control or advertisement register appears on `rd_data` as soon as that index is selected. A stale link copy shows as wrong status or partner words one cycle after `link_ok` moves. The bench sweeps many addresses against every index up to 31, and writes a pattern to each index. After each write it reads back all state-holding and link-derived registers. Any stray write decode is therefore caught on the next read.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;

    typedef struct packed {
        logic [7:0] phy;
        logic [7:0] idx;
    } sel_t;

    localparam logic [7:0] IX_CTL   = 8'd0;
    localparam logic [7:0] IX_STAT  = 8'd1;
    localparam logic [7:0] IX_ID_HI = 8'd2;
    localparam logic [7:0] IX_ID_LO = 8'd3;
    localparam logic [7:0] IX_ADV   = 8'd4;
    localparam logic [7:0] IX_LPA   = 8'd5;

    localparam int CTL_SOFT_RST_BIT = 15;
    localparam int ST_LINK_BIT      = 2;
    localparam int ST_ANDONE_BIT    = 5;

    localparam logic [15:0] CTL_DEFAULT = 16'h3100;
    localparam logic [15:0] ADV_DEFAULT = 16'h01E1;
    localparam logic [15:0] ST_CAPS     = 16'h7848;
    localparam logic [15:0] LPA_UP      = 16'h01E1;
    localparam logic [15:0] LPA_DOWN    = 16'h0080;
    localparam logic [15:0] NOBODY      = 16'hFFFF;

    function automatic logic [15:0] status_word(input logic up);
        logic [15:0] w;
        w = ST_CAPS;
        w[ST_LINK_BIT]   = up;
        w[ST_ANDONE_BIT] = up;
        return w;
    endfunction

    function automatic logic [15:0] partner_word(input logic up);
        return up ? LPA_UP : LPA_DOWN;
    endfunction

endpackage

// File: rtl/phy_mgmt_select.sv
module phy_mgmt_select
    import phy_mgmt_pkg::*;
#(
    parameter int         SEL_W    = 16,
    parameter int         ADDR_LSB = 8,
    parameter int         IDX_LSB  = 0,
    parameter logic [7:0] PHY_ADDR = 8'd1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sel_we,
    input  logic [SEL_W-1:0] sel_wdata,
    output sel_t             sel,
    output logic             hit
);
    sel_t sel_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= '0;
        end else if (sel_we) begin
            sel_q.phy <= sel_wdata[ADDR_LSB +: 8];
            sel_q.idx <= sel_wdata[IDX_LSB +: 8];
        end
    end

    assign sel = sel_q;
    assign hit = (sel_q.phy == PHY_ADDR);

    // R10: the selector follows the bus word on the edge where it is loaded
    a_r10_sel_load: assert property (@(posedge clk) disable iff (rst)
        sel_we |=> sel.idx == $past(sel_wdata[IDX_LSB +: 8]));
endmodule

// File: rtl/phy_mgmt_regs.sv
module phy_mgmt_regs
    import phy_mgmt_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  sel_t        sel,
    input  logic        hit,
    input  logic        wr_stb,
    input  logic [15:0] wr_data,
    input  logic        link_ok,
    output logic [15:0] ctl_o,
    output logic [15:0] adv_o,
    output logic [15:0] stat_o,
    output logic [15:0] lpa_o
);
    logic [15:0] ctl_q, adv_q;
    logic        link_q;
    logic        wr_ctl, wr_adv;

    assign wr_ctl = wr_stb && hit && (sel.idx == IX_CTL);
    assign wr_adv = wr_stb && hit && (sel.idx == IX_ADV);

    always_ff @(posedge clk) begin
        link_q <= link_ok;
        if (rst) begin
            ctl_q <= CTL_DEFAULT;
            adv_q <= ADV_DEFAULT;
        end else if (wr_ctl && wr_data[CTL_SOFT_RST_BIT]) begin
            ctl_q <= CTL_DEFAULT;
            adv_q <= ADV_DEFAULT;
        end else begin
            if (wr_ctl) ctl_q <= wr_data;
            if (wr_adv) adv_q <= wr_data;
        end
    end

    assign ctl_o  = ctl_q;
    assign adv_o  = adv_q;
    assign stat_o = status_word(link_q);
    assign lpa_o  = partner_word(link_q);

    // R2: defaults present on the first cycle after reset
    a_r2_reset_defaults: assert property (@(posedge clk)
        rst |=> (ctl_o == CTL_DEFAULT) && (adv_o == ADV_DEFAULT));
    // R5: soft reset reloads instead of storing
    a_r5_soft_reset: assert property (@(posedge clk) disable iff (rst)
        (wr_ctl && wr_data[CTL_SOFT_RST_BIT]) |=>
            (ctl_o == CTL_DEFAULT) && (adv_o == ADV_DEFAULT));
    // R3, R9: link up reaches status on the next edge
    a_r3_link_up: assert property (@(posedge clk) disable iff (rst)
        link_ok |=> stat_o[ST_LINK_BIT] && stat_o[ST_ANDONE_BIT] && (lpa_o == LPA_UP));
    // R4, R9: link down clears status bits and reduces partner ability
    a_r4_link_down: assert property (@(posedge clk) disable iff (rst)
        !link_ok |=> !stat_o[ST_LINK_BIT] && !stat_o[ST_ANDONE_BIT] && (lpa_o == LPA_DOWN));
endmodule

// File: rtl/phy_mgmt_rdmux.sv
module phy_mgmt_rdmux
    import phy_mgmt_pkg::*;
#(
    parameter logic [15:0] ID_HI = 16'h0141,
    parameter logic [15:0] ID_LO = 16'h0C25
) (
    input  sel_t        sel,
    input  logic        hit,
    input  logic [15:0] ctl,
    input  logic [15:0] stat,
    input  logic [15:0] adv,
    input  logic [15:0] lpa,
    output logic [15:0] rd
);
    always_comb begin
        rd = 16'h0000;
        if (!hit) begin
            rd = NOBODY;
        end else begin
            case (sel.idx)
                IX_CTL:   rd = ctl;
                IX_STAT:  rd = stat;
                IX_ID_HI: rd = ID_HI;
                IX_ID_LO: rd = ID_LO;
                IX_ADV:   rd = adv;
                IX_LPA:   rd = lpa;
                default:  rd = 16'h0000;
            endcase
        end
    end
endmodule

// File: rtl/phy_mgmt_regfile.sv
module phy_mgmt_regfile
    import phy_mgmt_pkg::*;
#(
    parameter logic [7:0]  PHY_ADDR = 8'd1,
    parameter logic [15:0] ID_HI    = 16'h0141,
    parameter logic [15:0] ID_LO    = 16'h0C25,
    parameter int          SEL_W    = 16,
    parameter int          ADDR_LSB = 8,
    parameter int          IDX_LSB  = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sel_we,
    input  logic [SEL_W-1:0] sel_wdata,
    input  logic             wr_stb,
    input  logic [15:0]      wr_data,
    input  logic             link_ok,
    output logic [15:0]      rd_data
);
    sel_t        sel;
    logic        hit;
    logic [15:0] ctl, adv, stat, lpa;

    phy_mgmt_select #(
        .SEL_W(SEL_W), .ADDR_LSB(ADDR_LSB), .IDX_LSB(IDX_LSB), .PHY_ADDR(PHY_ADDR)
    ) u_sel (
        .clk(clk), .rst(rst), .sel_we(sel_we), .sel_wdata(sel_wdata),
        .sel(sel), .hit(hit)
    );

    phy_mgmt_regs u_regs (
        .clk(clk), .rst(rst), .sel(sel), .hit(hit), .wr_stb(wr_stb),
        .wr_data(wr_data), .link_ok(link_ok),
        .ctl_o(ctl), .adv_o(adv), .stat_o(stat), .lpa_o(lpa)
    );

    phy_mgmt_rdmux #(.ID_HI(ID_HI), .ID_LO(ID_LO)) u_mux (
        .sel(sel), .hit(hit), .ctl(ctl), .stat(stat), .adv(adv), .lpa(lpa),
        .rd(rd_data)
    );

    // R1: a write aimed at another PHY leaves the stored registers untouched
    a_r1_foreign_write: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && !hit) |=> $stable(ctl) && $stable(adv));
    // R7, R8: writes to indices other than control and advertisement touch nothing
    a_r7_readonly_write: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && sel.idx != IX_CTL && sel.idx != IX_ADV) |=> $stable(ctl) && $stable(adv));
endmodule

// File: tb/phy_mgmt_regfile_test.sv
`timescale 1ns/1ps
module phy_mgmt_regfile_test;
    localparam logic [7:0]  PHY   = 8'd1;
    localparam logic [15:0] IDH   = 16'h0141;
    localparam logic [15:0] IDL   = 16'h0C25;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sel_we = 1'b0;
    logic [15:0] sel_wdata = '0;
    logic        wr_stb = 1'b0;
    logic [15:0] wr_data = '0;
    logic        link_ok = 1'b1;
    logic [15:0] rd_data;

    int vectors = 0;
    int errors  = 0;

    logic [15:0] m_ctl, m_adv;
    logic        m_link;

    always #2.5 clk = ~clk;

    phy_mgmt_regfile #(.PHY_ADDR(PHY), .ID_HI(IDH), .ID_LO(IDL)) uut (
        .clk(clk), .rst(rst), .sel_we(sel_we), .sel_wdata(sel_wdata),
        .wr_stb(wr_stb), .wr_data(wr_data), .link_ok(link_ok), .rd_data(rd_data)
    );

    function automatic logic [15:0] expect_rd(input logic [7:0] a, input logic [7:0] i);
        if (a != PHY) return 16'hFFFF;
        case (i)
            8'd0: return m_ctl;
            8'd1: return 16'h7848 | (m_link ? 16'h0024 : 16'h0000);
            8'd2: return IDH;
            8'd3: return IDL;
            8'd4: return m_adv;
            8'd5: return m_link ? 16'h01E1 : 16'h0080;
            default: return 16'h0000;
        endcase
    endfunction

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        vectors++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] a, input logic [7:0] i);
        @(negedge clk);
        sel_we = 1'b1;
        sel_wdata = {a, i};
        @(negedge clk);
        sel_we = 1'b0;
        check(tag, rd_data, expect_rd(a, i));
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] i, input logic [15:0] v);
        @(negedge clk);
        sel_we = 1'b1;
        sel_wdata = {a, i};
        @(negedge clk);
        sel_we = 1'b0;
        wr_stb = 1'b1;
        wr_data = v;
        @(negedge clk);
        wr_stb = 1'b0;
        if (a == PHY) begin
            if (i == 8'd0) begin
                if (v[15]) begin
                    m_ctl = 16'h3100;
                    m_adv = 16'h01E1;
                end else begin
                    m_ctl = v;
                end
            end else if (i == 8'd4) begin
                m_adv = v;
            end
        end
    endtask

    task automatic state_chk(input string tag);
        for (int k = 0; k < 6; k++) rd_chk(tag, PHY, 8'(k));
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        m_ctl = 16'h3100;
        m_adv = 16'h01E1;
        m_link = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R2 R3 R4 R8 reset contents with link up
        state_chk("R2 reset contents");
        check("R2 control default", expect_rd(PHY, 0), 16'h3100);

        // R1 R8 R10 sweep of addresses and indices
        for (int a = 0; a < 16; a++)
            for (int i = 0; i < 32; i++)
                rd_chk(a == PHY ? "R8 index sweep" : "R1 foreign read", 8'(a), 8'(i));
        rd_chk("R1 foreign read", 8'hFF, 8'd0);
        rd_chk("R8 high index", PHY, 8'hFF);
        rd_chk("R8 expansion index", PHY, 8'd6);

        // R6 R7 R8 write each index, verify state after each
        for (int i = 0; i < 32; i++) begin
            wr(PHY, 8'(i), (i == 0) ? 16'h1140 : (16'h5A00 | 16'(i)));
            state_chk((i == 0 || i == 4) ? "R6 stored write" : "R7 ignored write");
        end
        wr(PHY, 8'd200, 16'h7777);
        state_chk("R8 undefined index write");

        // R1 foreign writes
        wr(8'd0, 8'd0, 16'h0000);
        wr(8'd2, 8'd4, 16'h0001);
        wr(8'hFF, 8'd0, 16'h8000);
        state_chk("R1 foreign write");

        // R5 soft reset with value discarded
        wr(PHY, 8'd0, 16'h0400);
        wr(PHY, 8'd4, 16'h0021);
        state_chk("R6 stored write");
        wr(PHY, 8'd0, 16'h9234);
        state_chk("R5 soft reset");

        // R9 R4 link down without bus access
        rd_chk("R9 select status", PHY, 8'd1);
        @(negedge clk);
        link_ok = 1'b0;
        m_link = 1'b0;
        @(negedge clk);
        check("R9 R3 status after link drop", rd_data, 16'h7848);
        state_chk("R4 link down");

        // R5 soft reset while link down keeps link state
        wr(PHY, 8'd4, 16'h0061);
        wr(PHY, 8'd0, 16'hFFFF);
        state_chk("R5 soft reset link down");

        // R9 link back up
        rd_chk("R9 select partner", PHY, 8'd5);
        @(negedge clk);
        link_ok = 1'b1;
        m_link = 1'b1;
        @(negedge clk);
        check("R9 R4 partner after link rise", rd_data, 16'h01E1);
        state_chk("R3 link up");

        // R2 hard reset restores defaults
        wr(PHY, 8'd0, 16'h0000);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        m_ctl = 16'h3100;
        m_adv = 16'h01E1;
        state_chk("R2 reset again");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule